// File: doc/BRIEF.md
# Select-Gated Synchronous Byte Memory

This block is a small synchronous read/write store of bytes, driven by two control levels: an active-low select and a read/write level. Both are sampled only at the rising clock edge. When the unit is selected with the read/write level low, the byte on the write bus is loaded into the addressed location. When it is selected with the level high, the addressed byte comes out on the read bus one cycle later, and a valid flag marks it. When the unit is not selected, nothing is read or written, whatever the read/write level is.

Each location is a byte-wide register with a load enable, so it keeps its contents until a write decodes to it. A real tri-state output is modelled here by the valid flag together with a read bus forced to zero. The address width is a parameter, and the default gives 256 locations. A synchronous reset clears the output stage and leaves the stored bytes as they are.

Top module: `sel_sram`

## Requirements
- R1: While `sel_n` is 1 at a rising edge, no location changes and `rvalid` is 0 in the following cycle, for either level of `rd_wrn`.
- R2: With `sel_n`=0 and `rd_wrn`=0 at a rising edge, the location at `addr` takes `wdata`, no other location changes, and `rvalid` is 0 in the following cycle.
- R3: With `sel_n`=0 and `rd_wrn`=1 at a rising edge, the next cycle shows `rvalid`=1 and `rdata` equal to the byte stored at `addr` at that edge.
- R4: Whenever `rvalid` is 0, `rdata` is all zeros.
- R5: A location keeps its byte across any number of edges until a write is decoded for it, so a read returns the byte most recently written to it.
- R6: `rst` is synchronous and active high. An edge with `rst`=1 gives `rvalid`=0 and `rdata`=0 in the following cycle, even if a read was requested, and it does not alter any stored byte.
- R7: Only the control, address and data values present at the rising edge count. A write request that is withdrawn before the edge changes nothing.
- R8: Each address selects one 8-bit location, and there are 2^`ADDR_W` of them (256 by default). Read latency is one cycle at every address, including 0 and the highest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, output stage only |
| sel_n | input | 1 | Unit select, active low |
| rd_wrn | input | 1 | 1 = read, 0 = write; meaningful only while selected |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Byte to store |
| rdata | output | 8 | Byte read, zero when not valid |
| rvalid | output | 1 | Read bus is driven this cycle |

## Verification
On every cycle the assertions check how a sampled control pair maps onto the valid flag in the next cycle, that the read bus is zero whenever the flag is low, that read data equals the array output captured at the read edge, and that any location not being loaded keeps its byte. Only the bench scenarios can show that a location holds across long gaps and through a reset. The same applies to a write that is withdrawn before the edge, to reads at the extreme addresses, and to agreement with a reference array over a long randomized mix of reads, writes and idles.

// File: rtl/sel_sram_pkg.sv
package sel_sram_pkg;

    localparam int BYTE_W = 8;

    // decoded access for one clock edge
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } mem_op_e;

    // registered output stage
    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] dat;
    } rd_stage_s;

endpackage

// File: rtl/sel_sram_decode.sv
module sel_sram_decode
    import sel_sram_pkg::*;
(
    input  logic    sel_n,
    input  logic    rd_wrn,
    output mem_op_e op
);

    // the read/write level only counts while selected
    always_comb begin
        if (sel_n) begin
            op = OP_IDLE;
        end else if (rd_wrn) begin
            op = OP_READ;
        end else begin
            op = OP_WRITE;
        end
    end

endmodule

// File: rtl/sel_sram_cell.sv
module sel_sram_cell #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] q_d, q_q;

    // load-enabled D register; rst is not applied to contents
    always_comb begin
        q_d = q_q;
        if (ld) begin
            q_d = d;
        end
    end

    always_ff @(posedge clk) begin
        q_q <= q_d;
    end

    assign q = q_q;

    // R5: contents unchanged on any edge without a load
    a_r5_hold_unless_load: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(q_q));

endmodule

// File: rtl/sel_sram_array.sv
module sel_sram_array #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_q [DEPTH];
    logic [DEPTH-1:0]  ld_vec;

    for (genvar i = 0; i < DEPTH; i++) begin : g_loc
        assign ld_vec[i] = wr_en && (addr == ADDR_W'(i));

        sel_sram_cell #(.DATA_W(DATA_W)) u_cell (
            .clk (clk),
            .rst (rst),
            .ld  (ld_vec[i]),
            .d   (wdata),
            .q   (word_q[i])
        );
    end

    // flat mux: same depth of logic for every address
    assign rd_word = word_q[addr];

    // R2: a write loads exactly one location, and nothing loads otherwise
    a_r2_single_load: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $onehot(ld_vec));
    a_r1_no_load_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> (ld_vec == '0));

endmodule

// File: rtl/sel_sram_rdport.sv
module sel_sram_rdport
    import sel_sram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] rd_word,
    output logic [BYTE_W-1:0] rdata,
    output logic              rvalid
);

    rd_stage_s st_d, st_q;

    always_comb begin
        st_d     = '0;
        if (rst) begin
            st_d = '0;
        end else if (rd_en) begin
            st_d.vld = 1'b1;
            st_d.dat = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata  = st_q.dat;
    assign rvalid = st_q.vld;

    // R4: a disconnected bus reads as zero
    a_r4_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> (rdata == '0));

endmodule

// File: rtl/sel_sram.sv
module sel_sram
    import sel_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              rd_wrn,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              rvalid
);

    mem_op_e           op;
    logic [BYTE_W-1:0] rd_word;
    logic              wr_en;
    logic              rd_en;

    sel_sram_decode u_dec (
        .sel_n  (sel_n),
        .rd_wrn (rd_wrn),
        .op     (op)
    );

    assign wr_en = (op == OP_WRITE);
    assign rd_en = (op == OP_READ);

    sel_sram_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_arr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_word (rd_word)
    );

    sel_sram_rdport u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_word (rd_word),
        .rdata   (rdata),
        .rvalid  (rvalid)
    );

    // R1: deselected edge never yields a valid read
    a_r1_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> !rvalid);
    // R2: a write edge yields no valid read
    a_r2_write_no_valid: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && !rd_wrn) |=> !rvalid);
    // R3: a read edge yields a valid byte one cycle later
    a_r3_read_valid: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && rd_wrn) |=> rvalid);
    // R3: the byte is the array word present at the read edge
    a_r3_read_data: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && rd_wrn) |=> (rdata == $past(rd_word)));

endmodule

// File: tb/sel_sram_tb.sv
module sel_sram_tb;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_n = 1'b1;
    logic          rd_wrn = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          rvalid;

    always #4 clk = ~clk;   // 125 MHz

    sel_sram #(.ADDR_W(AW)) u_dut (
        .clk    (clk),
        .rst    (rst),
        .sel_n  (sel_n),
        .rd_wrn (rd_wrn),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    typedef struct {
        logic       vld;
        logic [7:0] dat;
        string      req;
    } exp_t;

    exp_t       sb_q [$];
    logic [7:0] ref_mem [DEPTH];
    int         n_vec  = 0;
    int         n_fail = 0;
    bit         done   = 0;

    // monitor: compare result of the previous edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_vec++;
            if (rvalid !== e.vld || rdata !== e.dat) begin
                n_fail++;
                $display("FAIL %s: got vld=%0b dat=%02h, expected vld=%0b dat=%02h",
                         e.req, rvalid, rdata, e.vld, e.dat);
            end
        end
    end

    // driver: apply one edge's inputs and push the expected result
    task automatic apply(input logic r, input logic s, input logic w,
                         input logic [AW-1:0] a, input logic [7:0] d,
                         input string req);
        exp_t e;
        @(negedge clk);
        #1;
        rst = r; sel_n = s; rd_wrn = w; addr = a; wdata = d;
        e.req = req;
        if (!r && !s && w) begin
            e.vld = 1'b1; e.dat = ref_mem[a];
        end else begin
            e.vld = 1'b0; e.dat = 8'h00;
        end
        if (!s && !w) ref_mem[a] = d;
        sb_q.push_back(e);
    endtask

    // write request withdrawn before the edge
    task automatic glitch_write(input logic [AW-1:0] a, input logic [7:0] d);
        exp_t e;
        @(negedge clk);
        #1;
        rst = 0; sel_n = 0; rd_wrn = 0; addr = a; wdata = d;
        #2;
        sel_n = 1; rd_wrn = 1;
        e.vld = 1'b0; e.dat = 8'h00; e.req = "R7";
        sb_q.push_back(e);
    endtask

    initial begin
        // R6: reset state, including a read requested under reset
        apply(1, 1, 1, '0, 8'h00, "R6");
        apply(1, 0, 1, '0, 8'h00, "R6");
        apply(1, 1, 0, '0, 8'h00, "R6");
        // R2 / R8: fill every byte
        for (int i = 0; i < DEPTH; i++) begin
            apply(0, 0, 0, AW'(i), 8'(i) ^ 8'hA5, "R2");
        end
        // write, idle with each rd_wrn level, read back (R1, R3)
        apply(0, 0, 0, AW'(8'h10), 8'h3C, "R2");
        apply(0, 1, 0, AW'(8'h10), 8'hFF, "R1");
        apply(0, 1, 1, AW'(8'h10), 8'hEE, "R1");
        apply(0, 0, 1, AW'(8'h10), 8'h00, "R3");
        apply(0, 1, 1, '0, 8'h00, "R4");
        // R8: extreme addresses, one-cycle latency, back-to-back reads
        apply(0, 0, 1, '0, 8'h00, "R8");
        apply(0, 0, 1, '1, 8'h00, "R8");
        apply(0, 0, 0, '1, 8'h5A, "R8");
        apply(0, 0, 1, '1, 8'h00, "R8");
        // R7: withdrawn write leaves the byte
        glitch_write(AW'(8'h20), 8'h99);
        apply(0, 0, 1, AW'(8'h20), 8'h00, "R7");
        // R6: mid-run reset keeps contents
        apply(1, 0, 1, AW'(8'h10), 8'h00, "R6");
        apply(1, 1, 1, AW'(8'h10), 8'h00, "R6");
        apply(0, 0, 1, AW'(8'h10), 8'h00, "R6");
        // R5: randomized mix against the reference array
        for (int k = 0; k < 2000; k++) begin
            logic [1:0] kind;
            kind = 2'($urandom_range(0, 3));
            case (kind)
                2'd0:    apply(0, 1, 1'($urandom), AW'($urandom), 8'($urandom), "R5");
                2'd1:    apply(0, 0, 0, AW'($urandom), 8'($urandom), "R5");
                default: apply(0, 0, 1, AW'($urandom), 8'($urandom), "R5");
            endcase
        end
        apply(0, 1, 1, '0, 8'h00, "R4");
        @(negedge clk);
        @(negedge clk);
        #2;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule